// File: doc/BRIEF.md
# Calibrated ADC Code to Millivolt Converter

This block turns a raw 10-bit converter code and a channel number into a scaled result. The result is in millivolts, or in a temperature-related unit for the two temperature channels. Three channels can carry a per-channel calibration: a gain and an offset, both scaled by 1000. When the stored gain of such a channel is nonzero, the result is `(code * gain + offset) / 1000`. A sequential divider computes that quotient over several cycles. In every other case the result comes from a fixed linear range, `lo + (hi - lo) * code / 1024`, and the divide by 1024 is a right shift.

A request is accepted with a valid/ready handshake. The response is held with a valid/ready handshake and carries the result and an error flag. Only one request is in flight at any time. Coefficients are written through a separate write port. One write sets both the gain and the offset of one calibration slot.

Top module: `adc_code_scaler`

## Requirements
- R1: Channels use these fixed ranges (lo..hi): 0 main charger voltage 0..20030, 1 battery temperature 0..1350, 2 battery voltage 2300..4800, 3 die temperature 0..1350, 4 accessory detect 0..2500, 5 auxiliary charger voltage 0..20030, 6 charger current 0..1500, 7 backup battery 0..3200. The uncalibrated result is lo + floor((hi-lo)*code/1024), with out_err low.
- R2: For channels 0, 1 and 2 (calibration slot = channel number) with a nonzero stored gain, the result is (code*gain + offset)/1000. Gain is unsigned 32-bit, offset is signed 32-bit, and the sum is formed in a 48-bit signed accumulator.
- R3: A calibration channel whose stored gain is zero uses its fixed range from R1, whatever its offset.
- R4: Channel numbers 8 to 15 give a response with out_err high and out_data equal to 0.
- R5: in_ready is low from the cycle after a request is accepted until the response handshake completes. It is high again in the cycle after that handshake.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data and out_err stay unchanged.
- R7: A fixed-range or error response has out_valid high in the cycle after acceptance. A calibrated request raises busy in the cycle after acceptance. busy stays high and out_valid stays low until the quotient is ready.
- R8: A request uses the coefficients stored before its acceptance edge. A coefficient write in the same cycle as acceptance, or during a division, affects only later requests.
- R9: After reset, in_ready is high, out_valid and busy are low, and every stored gain is zero, so all channels use R1.
- R10: A negative calibrated sum divides with truncation toward zero (for example, -400500/1000 gives -400).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_chan | input | 4 | Channel number |
| in_code | input | CODE_W | Raw converter code |
| out_valid | output | 1 | Response valid |
| out_ready | input | 1 | Response consumed when high with out_valid |
| out_data | output | RES_W | Signed result |
| out_err | output | 1 | Unknown channel flag |
| busy | output | 1 | Calibrated division in progress |
| cw_en | input | 1 | Coefficient write strobe |
| cw_slot | input | SLOT_W | Calibration slot written |
| cw_gain | input | GAIN_W | Unsigned gain (x1000) |
| cw_offset | input | OFFS_W | Signed offset (x1000) |

## Verification
A coefficient write and a request acceptance can fall on the same clock edge and touch the same calibration slot. The bench provokes this by raising cw_en and in_valid together for channel 0. The response must use the gain held before that edge, and a second request must then use the new gain. A write issued while a division is running is also judged: that response must still show the old gain.

// File: rtl/acs_pkg.sv
package acs_pkg;
   localparam int CH_W     = 4;
   localparam int KNOWN_CH = 8;
   localparam int RNG_W    = 16;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_DIVIDE,
      ST_RESPOND
   } acs_state_e;

   function automatic logic [RNG_W-1:0] rng_lo(input logic [CH_W-1:0] ch);
      case (ch)
         4'd2:    return 16'd2300;
         default: return 16'd0;
      endcase
   endfunction

   function automatic logic [RNG_W-1:0] rng_hi(input logic [CH_W-1:0] ch);
      case (ch)
         4'd0, 4'd5: return 16'd20030;
         4'd1, 4'd3: return 16'd1350;
         4'd2:       return 16'd4800;
         4'd4:       return 16'd2500;
         4'd6:       return 16'd1500;
         4'd7:       return 16'd3200;
         default:    return 16'd0;
      endcase
   endfunction

   function automatic logic chan_known(input logic [CH_W-1:0] ch);
      return ch < CH_W'(KNOWN_CH);
   endfunction
endpackage

// File: rtl/acs_fixed_map.sv
module acs_fixed_map
   import acs_pkg::*;
#(
   parameter int CODE_W = 10,
   parameter int RES_W  = 32
) (
   input  logic [CH_W-1:0]         chan,
   input  logic [CODE_W-1:0]       code,
   output logic signed [RES_W-1:0] value,
   output logic                    known
);
   localparam int PROD_W = RNG_W + CODE_W;

   generate
      if (RES_W <= RNG_W) begin : g_bad_res
         $error("acs_fixed_map: RES_W must exceed the range width");
      end
   endgenerate

   logic [RNG_W-1:0]  lo;
   logic [RNG_W-1:0]  span;
   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] scaled;

   always_comb begin
      lo     = rng_lo(chan);
      span   = rng_hi(chan) - lo;
      prod   = PROD_W'(span) * PROD_W'(code);
      scaled = prod >> CODE_W;
      value  = signed'(RES_W'(lo) + RES_W'(scaled));
      known  = chan_known(chan);
   end
endmodule

// File: rtl/acs_coef_bank.sv
module acs_coef_bank #(
   parameter int SLOTS  = 3,
   parameter int SLOT_W = 2,
   parameter int GAIN_W = 32,
   parameter int OFFS_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [SLOT_W-1:0]        wr_slot,
   input  logic [GAIN_W-1:0]        wr_gain,
   input  logic signed [OFFS_W-1:0] wr_offset,
   input  logic [SLOT_W-1:0]        rd_slot,
   output logic [GAIN_W-1:0]        rd_gain,
   output logic signed [OFFS_W-1:0] rd_offset
);
   generate
      if (SLOTS < 1 || (1 << SLOT_W) < SLOTS) begin : g_bad_slots
         $error("acs_coef_bank: SLOT_W cannot address SLOTS");
      end
   endgenerate

   logic [GAIN_W-1:0]        gain_q [SLOTS];
   logic signed [OFFS_W-1:0] offs_q [SLOTS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) begin
            gain_q[i] <= '0;
            offs_q[i] <= '0;
         end
      end else if (wr_en) begin
         for (int i = 0; i < SLOTS; i++) begin
            if (wr_slot == SLOT_W'(i)) begin
               gain_q[i] <= wr_gain;
               offs_q[i] <= wr_offset;
            end
         end
      end
   end

   always_comb begin
      rd_gain   = '0;
      rd_offset = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (rd_slot == SLOT_W'(i)) begin
            rd_gain   = gain_q[i];
            rd_offset = offs_q[i];
         end
      end
   end
endmodule

// File: rtl/acs_seq_div.sv
module acs_seq_div #(
   parameter int NUM_W = 48,
   parameter int DEN   = 1000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic signed [NUM_W-1:0] dividend,
   output logic                    busy,
   output logic                    done,
   output logic signed [NUM_W-1:0] quotient
);
   localparam int DEN_W  = $clog2(DEN + 1);
   localparam int ITER_W = $clog2(NUM_W + 1);

   generate
      if (DEN < 2) begin : g_bad_den
         $error("acs_seq_div: DEN must be at least 2");
      end
      if (NUM_W <= DEN_W) begin : g_bad_num
         $error("acs_seq_div: NUM_W too narrow for DEN");
      end
   endgenerate

   logic [DEN_W-1:0]  rem_q;
   logic [NUM_W-1:0]  quo_q;
   logic [ITER_W-1:0] cnt_q;
   logic              neg_q;
   logic              done_q;
   logic [DEN_W:0]    trial;
   logic              fits;

   always_comb begin
      trial = {rem_q, quo_q[NUM_W-1]};
      fits  = trial >= (DEN_W + 1)'(DEN);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         cnt_q  <= '0;
         neg_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (start) begin
         rem_q  <= '0;
         quo_q  <= dividend[NUM_W-1] ? NUM_W'(-dividend) : NUM_W'(dividend);
         cnt_q  <= ITER_W'(NUM_W);
         neg_q  <= dividend[NUM_W-1];
         done_q <= 1'b0;
      end else if (cnt_q != '0) begin
         rem_q  <= fits ? DEN_W'(trial - (DEN_W + 1)'(DEN)) : DEN_W'(trial);
         quo_q  <= {quo_q[NUM_W-2:0], fits};
         cnt_q  <= cnt_q - 1'b1;
         done_q <= (cnt_q == ITER_W'(1));
      end else begin
         done_q <= 1'b0;
      end
   end

   assign busy     = (cnt_q != '0);
   assign done     = done_q;
   assign quotient = neg_q ? -signed'(quo_q) : signed'(quo_q);

   AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_DIV_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R5
endmodule

// File: rtl/adc_code_scaler.sv
module adc_code_scaler
   import acs_pkg::*;
#(
   parameter int CODE_W    = 10,
   parameter int GAIN_W    = 32,
   parameter int OFFS_W    = 32,
   parameter int ACC_W     = 48,
   parameter int RES_W     = 32,
   parameter int SCALE     = 1000,
   parameter int CAL_SLOTS = 3,
   parameter int SLOT_W    = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [3:0]               in_chan,
   input  logic [CODE_W-1:0]        in_code,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic signed [RES_W-1:0]  out_data,
   output logic                     out_err,
   output logic                     busy,
   input  logic                     cw_en,
   input  logic [SLOT_W-1:0]        cw_slot,
   input  logic [GAIN_W-1:0]        cw_gain,
   input  logic signed [OFFS_W-1:0] cw_offset
);
   generate
      if (CAL_SLOTS < 1 || CAL_SLOTS > 3) begin : g_bad_cal
         $error("adc_code_scaler: CAL_SLOTS must be 1 to 3");
      end
      if (CODE_W + GAIN_W >= ACC_W) begin : g_bad_acc
         $error("adc_code_scaler: ACC_W too narrow for code times gain");
      end
      if (OFFS_W >= ACC_W || RES_W > ACC_W) begin : g_bad_widths
         $error("adc_code_scaler: offset or result wider than accumulator");
      end
      if (SLOT_W > CH_W) begin : g_bad_slot_w
         $error("adc_code_scaler: SLOT_W wider than channel field");
      end
   endgenerate

   acs_state_e               state_q;
   logic                     accept;
   logic                     is_cal_chan;
   logic                     use_cal;
   logic                     div_start;
   logic                     div_busy;
   logic                     div_done;
   logic signed [ACC_W-1:0]  div_quot;
   logic [GAIN_W-1:0]        rd_gain;
   logic signed [OFFS_W-1:0] rd_offset;
   logic signed [ACC_W-1:0]  prod_s;
   logic signed [ACC_W-1:0]  acc_s;
   logic signed [RES_W-1:0]  fixed_val;
   logic                     known;

   acs_coef_bank #(
      .SLOTS  (CAL_SLOTS),
      .SLOT_W (SLOT_W),
      .GAIN_W (GAIN_W),
      .OFFS_W (OFFS_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cw_en),
      .wr_slot   (cw_slot),
      .wr_gain   (cw_gain),
      .wr_offset (cw_offset),
      .rd_slot   (in_chan[SLOT_W-1:0]),
      .rd_gain   (rd_gain),
      .rd_offset (rd_offset)
   );

   acs_fixed_map #(
      .CODE_W (CODE_W),
      .RES_W  (RES_W)
   ) u_fixed (
      .chan  (in_chan),
      .code  (in_code),
      .value (fixed_val),
      .known (known)
   );

   always_comb begin
      is_cal_chan = (in_chan < CH_W'(CAL_SLOTS));
      use_cal     = is_cal_chan && (rd_gain != '0);
      prod_s      = signed'(ACC_W'(in_code)) * signed'(ACC_W'(rd_gain));
      acc_s       = prod_s + ACC_W'(rd_offset);
      accept      = in_valid && (state_q == ST_IDLE);
      div_start   = accept && known && use_cal;
   end

   acs_seq_div #(
      .NUM_W (ACC_W),
      .DEN   (SCALE)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (div_start),
      .dividend (acc_s),
      .busy     (div_busy),
      .done     (div_done),
      .quotient (div_quot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         out_data <= '0;
         out_err  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (!known) begin
                     out_data <= '0;
                     out_err  <= 1'b1;
                     state_q  <= ST_RESPOND;
                  end else if (use_cal) begin
                     out_err  <= 1'b0;
                     state_q  <= ST_DIVIDE;
                  end else begin
                     out_data <= fixed_val;
                     out_err  <= 1'b0;
                     state_q  <= ST_RESPOND;
                  end
               end
            end
            ST_DIVIDE: begin
               if (div_done) begin
                  out_data <= RES_W'(div_quot);
                  state_q  <= ST_RESPOND;
               end
            end
            ST_RESPOND: begin
               if (out_ready) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign in_ready  = (state_q == ST_IDLE);
   assign out_valid = (state_q == ST_RESPOND);
   assign busy      = (state_q == ST_DIVIDE);

   AST_READY_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready |=> in_ready); // R5
   AST_NO_READY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> !in_ready); // R5
   AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_err)); // R6
   AST_UNKNOWN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !known |=> out_valid && out_err && (out_data == '0)); // R4
   AST_DIV_TO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      div_done |=> out_valid && !out_err); // R7
   AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      div_start |=> busy && div_busy && !out_valid); // R7
endmodule

// File: tb/adc_code_scaler_bench.sv
module adc_code_scaler_bench;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic               in_ready;
   logic [3:0]         in_chan = '0;
   logic [9:0]         in_code = '0;
   logic               out_valid;
   logic               out_ready = 1'b1;
   logic signed [31:0] out_data;
   logic               out_err;
   logic               busy;
   logic               cw_en = 1'b0;
   logic [1:0]         cw_slot = '0;
   logic [31:0]        cw_gain = '0;
   logic signed [31:0] cw_offset = '0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   adc_code_scaler u_adc_code_scaler (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan), .in_code(in_code),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_err(out_err),
      .busy(busy), .cw_en(cw_en), .cw_slot(cw_slot), .cw_gain(cw_gain), .cw_offset(cw_offset)
   );

   localparam int NV = 12;
   localparam int V_CH   [NV] = '{0, 0, 1, 2, 2, 3, 4, 5, 6, 7, 8, 15};
   localparam int V_CODE [NV] = '{512, 1023, 1023, 0, 1023, 100, 300, 1, 700, 1023, 5, 1023};
   localparam int V_EXP  [NV] = '{10015, 20010, 1348, 2300, 4797, 131, 732, 19, 1025, 3196, 0, 0};
   localparam int V_ERR  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1};

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr_coef(input int slot, input int unsigned gain, input int offs);
      @(negedge clk);
      cw_en = 1'b1; cw_slot = 2'(slot); cw_gain = gain; cw_offset = offs;
      @(negedge clk);
      cw_en = 1'b0;
   endtask

   // Issues one request, optionally with a coefficient write on the same edge.
   task automatic do_req(input int ch, input int code, input bit wen, input int wslot,
                         input int unsigned wgain, input int exp, input bit experr,
                         input bit fast, input string tag);
      int n;
      @(negedge clk);
      check({tag, " R5 in_ready idle"}, in_ready, 1);
      in_valid = 1'b1; in_chan = 4'(ch); in_code = 10'(code);
      if (wen) begin
         cw_en = 1'b1; cw_slot = 2'(wslot); cw_gain = wgain; cw_offset = 0;
      end
      @(negedge clk);
      in_valid = 1'b0; cw_en = 1'b0;
      if (!fast) begin
         check({tag, " R7 busy after accept"}, busy, 1);
         check({tag, " R7 no early response"}, out_valid, 0);
      end
      n = 0;
      while (!out_valid && n < 200) begin
         @(negedge clk);
         n++;
      end
      if (fast) check({tag, " R7 next-cycle response"}, n, 0);
      check({tag, " data"}, out_data, exp);
      check({tag, " err"}, out_err, experr);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 in_ready", in_ready, 1);
      check("R9 out_valid", out_valid, 0);
      check("R9 busy", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1, R3 (zero gains after reset, R9), R4: table walk
      for (int i = 0; i < NV; i++) begin
         do_req(V_CH[i], V_CODE[i], 1'b0, 0, 0, V_EXP[i], V_ERR[i][0], 1'b1,
                $sformatf("R1/R4 vec%0d ch%0d", i, V_CH[i]));
      end

      // R2: calibrated battery voltage
      wr_coef(2, 2444, 2299992);
      do_req(2, 500, 1'b0, 0, 0, 3521, 1'b0, 1'b0, "R2 cal ch2");
      // R10: negative sum truncates toward zero
      wr_coef(1, 1000, -500500);
      do_req(1, 100, 1'b0, 0, 0, -400, 1'b0, 1'b0, "R10 neg trunc ch1");
      // R2: main charger voltage
      wr_coef(0, 19185, 0);
      do_req(0, 997, 1'b0, 0, 0, 19127, 1'b0, 1'b0, "R2 cal ch0");

      // R8: write on acceptance edge uses old gain, later request uses new
      do_req(0, 997, 1'b1, 0, 2000, 19127, 1'b0, 1'b0, "R8 same-edge write");
      do_req(0, 997, 1'b0, 0, 0, 1994, 1'b0, 1'b0, "R8 new gain visible");

      // R8: write during division does not disturb the running request
      @(negedge clk);
      in_valid = 1'b1; in_chan = 4'd0; in_code = 10'd997;
      @(negedge clk);
      in_valid = 1'b0;
      cw_en = 1'b1; cw_slot = 2'd0; cw_gain = 3000; cw_offset = 0;
      @(negedge clk);
      cw_en = 1'b0;
      for (int k = 0; k < 200 && !out_valid; k++) @(negedge clk);
      check("R8 write during divide", out_data, 1994);

      // R3: zero gain falls back to fixed range even with an offset
      wr_coef(2, 0, 999);
      do_req(2, 0, 1'b0, 0, 0, 2300, 1'b0, 1'b1, "R3 zero gain ch2");

      // R6 and R5: back-pressure holds the response
      @(negedge clk);
      out_ready = 1'b0;
      do_req(7, 1023, 1'b0, 0, 0, 3196, 1'b0, 1'b1, "R6 bp first");
      repeat (4) @(negedge clk);
      check("R6 out_valid held", out_valid, 1);
      check("R6 data held", out_data, 3196);
      check("R5 in_ready low while pending", in_ready, 0);
      out_ready = 1'b1;
      @(negedge clk);
      check("R5 in_ready after handshake", in_ready, 1);
      check("R6 out_valid cleared", out_valid, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule